// File: doc/BRIEF.md
# Free-running 32 kHz sync counter

This block keeps a free-running tick counter that software reads over a simple register port. A one-cycle enable, synchronous to the bus clock, marks each tick of a 32768 Hz time base (0x8000 ticks per second). The counter clears on reset, then counts up for as long as the chip runs. Nothing can stop it, load it or write it.

The register port takes an address, a read strobe, a write strobe and a size code. It answers one cycle later with read data, a response-valid pulse and an access-error pulse. Two registers can be read: a fixed revision word and the live count. Software that can only issue 16-bit reads gets a coherent 32-bit value from two halves. Reading the lower half also captures the upper half into a holding register. A later read of the upper half returns that held copy, not the live count.

Size codes on `bus_size`: 0 is 8-bit, 1 is 16-bit, 2 is 32-bit, and 3 is reserved. A cycle with both strobes high is handled as a write.

Top module: `sync_tick_counter`

## Requirements
- R1: After reset the count reads 0, the holding register holds 0, and `resp_valid`, `acc_err` and `rd_data` are 0.
- R2: The count grows by exactly one on each clock edge where `tick_en` is high, and holds its value otherwise. A tick in the same cycle as a read is counted after the read has taken its value.
- R3: The count wraps from all ones to 0 with no flag. With `CNT_W` below 32, the value is zero-extended to 32 bits.
- R4: A 32-bit read (size 2) at offset 0x00 returns 0x00000021 with `acc_err` low.
- R5: A 32-bit read at offset 0x10 returns the current count with `acc_err` low.
- R6: A 16-bit read (size 1) with address bit 1 clear returns bits 15:0 of the 32-bit register at that exact address and loads bits 31:16 into the holding register. At an invalid offset it returns 0, raises `acc_err` and loads 0.
- R7: A 16-bit read with address bit 1 set returns the holding register in bits 15:0, with `acc_err` low. It does not sample the live count.
- R8: A read of size 0 or 3 returns 0 and raises `acc_err`. It changes no state.
- R9: A write of any size returns 0 and raises `acc_err`. It changes neither the count nor the holding register.
- R10: A 32-bit read at any address other than 0x00 or 0x10 returns 0 and raises `acc_err`.
- R11: Each access cycle is answered on the next cycle by a one-cycle `resp_valid` pulse. `rd_data` and `acc_err` are valid with that pulse, and `acc_err` is never high without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle enable per 32768 Hz tick |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_size | input | 2 | Access size code (0 byte, 1 half, 2 word, 3 reserved) |
| bus_wdata | input | 32 | Write data (ignored) |
| rd_data | output | 32 | Read data, valid with resp_valid |
| resp_valid | output | 1 | Response pulse, one cycle after an access |
| acc_err | output | 1 | Bad-width or invalid-register pulse |

## Verification
A count register that skips or repeats shows up at once: the next 32-bit read at 0x10 differs from the number of ticks the bench has delivered. A wrong holding register stays hidden until a 16-bit upper-half read. The bench therefore loads the holding register with known values from different offsets, then reads it back in the next access. This also catches a design that reads the live count instead of the held copy. Decode faults show up in the response one cycle after the request, as wrong data or a missing or extra error pulse.

// File: rtl/synctmr_pkg.sv
package synctmr_pkg;

    localparam int DATA_W = 32;
    localparam int HALF_W = 16;

    localparam logic [DATA_W-1:0] REV_CODE = 32'h0000_0021;
    localparam int unsigned OFS_REV = 32'h00;
    localparam int unsigned OFS_CNT = 32'h10;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        SRC_ZERO = 2'd0,
        SRC_REV  = 2'd1,
        SRC_CNT  = 2'd2
    } word_src_e;

    typedef enum logic [1:0] {
        LANE_NONE = 2'd0,
        LANE_FULL = 2'd1,
        LANE_LOW  = 2'd2,
        LANE_HOLD = 2'd3
    } lane_e;

    typedef struct packed {
        logic      valid;
        logic      err;
        word_src_e src;
        lane_e     lane;
        logic      hold_ld;
    } dec_t;

    function automatic logic [DATA_W-1:0] shape_resp(
        input lane_e             lane,
        input logic [DATA_W-1:0] word,
        input logic [HALF_W-1:0] held
    );
        logic [DATA_W-1:0] r;
        case (lane)
            LANE_FULL: r = word;
            LANE_LOW:  r = {{(DATA_W-HALF_W){1'b0}}, word[HALF_W-1:0]};
            LANE_HOLD: r = {{(DATA_W-HALF_W){1'b0}}, held};
            default:   r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/synctmr_count.sv
module synctmr_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick_en) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/synctmr_decode.sv
module synctmr_decode
    import synctmr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              rd,
    input  logic              wr,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam logic [ADDR_W-1:0] A_REV = ADDR_W'(OFS_REV);
    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(OFS_CNT);

    word_src_e src_hit;
    logic      miss;

    always_comb begin
        miss = 1'b0;
        if (addr == A_REV) begin
            src_hit = SRC_REV;
        end else if (addr == A_CNT) begin
            src_hit = SRC_CNT;
        end else begin
            src_hit = SRC_ZERO;
            miss    = 1'b1;
        end
    end

    always_comb begin
        dec         = '0;
        dec.src     = SRC_ZERO;
        dec.lane    = LANE_NONE;
        if (wr) begin
            dec.valid = 1'b1;
            dec.err   = 1'b1;
        end else if (rd) begin
            dec.valid = 1'b1;
            case (acc_size_e'(size))
                ACC_WORD: begin
                    dec.src  = src_hit;
                    dec.err  = miss;
                    dec.lane = LANE_FULL;
                end
                ACC_HALF: begin
                    if (addr[1]) begin
                        dec.lane = LANE_HOLD;
                    end else begin
                        dec.src     = src_hit;
                        dec.err     = miss;
                        dec.lane    = LANE_LOW;
                        dec.hold_ld = 1'b1;
                    end
                end
                default: begin
                    dec.err = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/synctmr_hold.sv
module synctmr_hold #(
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [HOLD_W-1:0] din,
    output logic [HOLD_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end
    end
endmodule

// File: rtl/sync_tick_counter.sv
module sync_tick_counter
    import synctmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       rd_data,
    output logic              resp_valid,
    output logic              acc_err
);
    logic [CNT_W-1:0]  count_q;
    logic [DATA_W-1:0] cnt_word;
    logic [DATA_W-1:0] word_sel;
    logic [HALF_W-1:0] hold_q;
    logic [DATA_W-1:0] resp_d;
    dec_t              dec;
    logic              wdata_unused;

    assign wdata_unused = ^bus_wdata;

    synctmr_count #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .cnt     (count_q)
    );

    generate
        if (CNT_W < DATA_W) begin : g_ext
            assign cnt_word = {{(DATA_W-CNT_W){1'b0}}, count_q};
        end else begin : g_full
            assign cnt_word = count_q[DATA_W-1:0];
        end
    endgenerate

    synctmr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .rd   (bus_rd),
        .wr   (bus_wr),
        .size (bus_size),
        .addr (bus_addr),
        .dec  (dec)
    );

    always_comb begin
        case (dec.src)
            SRC_REV: word_sel = REV_CODE;
            SRC_CNT: word_sel = cnt_word;
            default: word_sel = '0;
        endcase
    end

    synctmr_hold #(.HOLD_W(HALF_W)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .load (dec.hold_ld),
        .din  (word_sel[DATA_W-1:HALF_W]),
        .q    (hold_q)
    );

    assign resp_d = shape_resp(dec.lane, word_sel, hold_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data    <= '0;
            resp_valid <= 1'b0;
            acc_err    <= 1'b0;
        end else begin
            rd_data    <= resp_d;
            resp_valid <= dec.valid;
            acc_err    <= dec.err;
        end
    end
endmodule

// File: rtl/sync_tick_counter_chk.sv
module sync_tick_counter_chk #(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [1:0]        bus_size,
    input logic [31:0]       rd_data,
    input logic              resp_valid,
    input logic              acc_err,
    input logic [CNT_W-1:0]  count_q,
    input logic [15:0]       hold_q
);
    // R2
    tick_step_chk: assert property (@(posedge clk) disable iff (rst)
        tick_en |=> count_q == CNT_W'($past(count_q) + 1'b1));
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(count_q));
    // R3
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_en && count_q == '1) |=> count_q == '0);
    // R4
    rev_word_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_size == 2'd2 && bus_addr == '0)
        |=> (rd_data == 32'h21 && !acc_err));
    // R7
    hold_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_size == 2'd1 && bus_addr[1])
        |=> (rd_data == {16'h0, $past(hold_q)} && !acc_err));
    // R8
    bad_width_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && (bus_size == 2'd0 || bus_size == 2'd3))
        |=> (acc_err && rd_data == '0 && $stable(hold_q)));
    // R9
    write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        bus_wr |=> (acc_err && rd_data == '0 && $stable(hold_q)));
    // R11
    resp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd || bus_wr) |=> resp_valid);
    // R11
    resp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd || bus_wr) |=> !resp_valid);
    // R11
    err_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        acc_err |-> resp_valid);
endmodule

bind sync_tick_counter sync_tick_counter_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick_en    (tick_en),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_size   (bus_size),
    .rd_data    (rd_data),
    .resp_valid (resp_valid),
    .acc_err    (acc_err),
    .count_q    (count_q),
    .hold_q     (hold_q)
);

// File: tb/tb_sync_tick_counter.sv
module tb_sync_tick_counter;
    localparam int SMALL_W = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd_data, rd_data_s;
    logic        resp_valid, resp_valid_s;
    logic        acc_err, acc_err_s;

    int          checks = 0;
    int          errors = 0;
    logic [31:0] exp_cnt = '0;
    logic [31:0] r_data, s_data;
    logic        r_err, r_vld;

    always #10 clk = ~clk;

    sync_tick_counter dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .rd_data(rd_data), .resp_valid(resp_valid),
        .acc_err(acc_err)
    );

    sync_tick_counter #(.CNT_W(SMALL_W)) dut_small (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .rd_data(rd_data_s), .resp_valid(resp_valid_s),
        .acc_err(acc_err_s)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // one access; starts and ends at a falling edge
    task automatic access(input logic rd, input logic wr, input logic [1:0] sz,
                          input logic [7:0] a, input logic tk);
        bus_rd = rd; bus_wr = wr; bus_size = sz; bus_addr = a;
        bus_wdata = 32'hFFFF_FFFF; tick_en = tk;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; tick_en = 1'b0;
        if (tk) exp_cnt = exp_cnt + 1;
        r_data = rd_data; r_err = acc_err; r_vld = resp_valid; s_data = rd_data_s;
        chk("R11 resp_valid", {31'b0, r_vld}, 32'd1);
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
        exp_cnt = exp_cnt + 32'(n);
    endtask

    task automatic t_reset;
        chk("R1 rd_data", rd_data, 32'h0);
        chk("R1 resp_valid", {31'b0, resp_valid}, 32'h0);
        chk("R1 acc_err", {31'b0, acc_err}, 32'h0);
        access(1, 0, 2'd2, 8'h10, 0);
        chk("R1 count zero", r_data, 32'h0);
        access(1, 0, 2'd1, 8'h12, 0);
        chk("R1 hold zero", r_data, 32'h0);
        @(negedge clk);
        chk("R11 single pulse", {31'b0, resp_valid}, 32'h0);
    endtask

    task automatic t_count;
        ticks(5);
        access(1, 0, 2'd2, 8'h10, 0);
        chk("R5 count", r_data, exp_cnt);
        chk("R5 no err", {31'b0, r_err}, 32'h0);
        repeat (3) @(negedge clk);
        access(1, 0, 2'd2, 8'h10, 0);
        chk("R2 idle stable", r_data, exp_cnt);
        access(1, 0, 2'd2, 8'h10, 1);
        chk("R2 same-cycle tick after read", r_data, exp_cnt - 1);
        access(1, 0, 2'd2, 8'h10, 0);
        chk("R2 tick counted", r_data, exp_cnt);
    endtask

    task automatic t_rev;
        access(1, 0, 2'd2, 8'h00, 0);
        chk("R4 revision", r_data, 32'h21);
        chk("R4 no err", {31'b0, r_err}, 32'h0);
        access(1, 0, 2'd1, 8'h00, 0);
        chk("R6 rev low half", r_data, 32'h21);
        access(1, 0, 2'd1, 8'h02, 0);
        chk("R6 rev upper held", r_data, 32'h0);
    endtask

    task automatic t_half;
        ticks(70000);
        access(1, 0, 2'd2, 8'h10, 0);
        chk("R5 large count", r_data, exp_cnt);
        access(1, 0, 2'd1, 8'h10, 0);
        chk("R6 count low half", r_data, {16'h0, exp_cnt[15:0]});
        chk("R6 no err", {31'b0, r_err}, 32'h0);
        ticks(7);
        access(1, 0, 2'd1, 8'h12, 0);
        chk("R7 held upper", r_data, {16'h0, exp_cnt[31:16]});
        chk("R7 no err", {31'b0, r_err}, 32'h0);
        access(1, 0, 2'd1, 8'h00, 0);
        access(1, 0, 2'd1, 8'h12, 0);
        chk("R7 not live count", r_data, 32'h0);
        access(1, 0, 2'd1, 8'h10, 0);
        access(1, 0, 2'd1, 8'h04, 0);
        chk("R6 invalid low data", r_data, 32'h0);
        chk("R6 invalid low err", {31'b0, r_err}, 32'h1);
        access(1, 0, 2'd1, 8'h06, 0);
        chk("R6 invalid loads zero", r_data, 32'h0);
    endtask

    task automatic t_byte;
        access(1, 0, 2'd1, 8'h10, 0);
        access(1, 0, 2'd0, 8'h10, 0);
        chk("R8 byte data", r_data, 32'h0);
        chk("R8 byte err", {31'b0, r_err}, 32'h1);
        access(1, 0, 2'd3, 8'h00, 0);
        chk("R8 reserved size err", {31'b0, r_err}, 32'h1);
        access(1, 0, 2'd1, 8'h12, 0);
        chk("R8 hold untouched", r_data, {16'h0, exp_cnt[31:16]});
    endtask

    task automatic t_write;
        access(1, 0, 2'd1, 8'h10, 0);
        access(0, 1, 2'd2, 8'h10, 0);
        chk("R9 write err", {31'b0, r_err}, 32'h1);
        chk("R9 write data", r_data, 32'h0);
        access(0, 1, 2'd1, 8'h00, 0);
        chk("R9 half write err", {31'b0, r_err}, 32'h1);
        access(1, 1, 2'd1, 8'h00, 0);
        chk("R9 rd+wr is write", {31'b0, r_err}, 32'h1);
        access(1, 0, 2'd1, 8'h12, 0);
        chk("R9 hold kept", r_data, {16'h0, exp_cnt[31:16]});
        access(1, 0, 2'd2, 8'h10, 0);
        chk("R9 count kept", r_data, exp_cnt);
    endtask

    task automatic t_bad_word;
        access(1, 0, 2'd2, 8'h04, 0);
        chk("R10 data 0x04", r_data, 32'h0);
        chk("R10 err 0x04", {31'b0, r_err}, 32'h1);
        access(1, 0, 2'd2, 8'h11, 0);
        chk("R10 err 0x11", {31'b0, r_err}, 32'h1);
        access(1, 0, 2'd2, 8'h14, 0);
        chk("R10 data 0x14", r_data, 32'h0);
    endtask

    task automatic t_wrap;
        access(1, 0, 2'd2, 8'h10, 0);
        chk("R3 small modulo", s_data, {26'h0, exp_cnt[5:0]});
        if (exp_cnt[5:0] != 6'h3F) ticks(int'(6'h3F - exp_cnt[5:0]));
        access(1, 0, 2'd2, 8'h10, 0);
        chk("R3 small at max", s_data, 32'h3F);
        ticks(1);
        access(1, 0, 2'd2, 8'h10, 0);
        chk("R3 wrapped to zero", s_data, 32'h0);
        chk("R3 no flag", {31'b0, acc_err_s}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_count;
        t_rev;
        t_half;
        t_byte;
        t_write;
        t_bad_word;
        t_wrap;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule